// File: doc/BRIEF.md
# Battery Over-Discharge Protection Sequencer

This block is the digital sequencer of a four-cell battery pack protector. Comparators outside the block report, for each cell, whether the cell is under its discharge limit and whether it is under its charge-enable level. A millisecond tick paces every timer. When any cell reports under-voltage, the block starts a qualification delay. Both FET gates stay on while that delay runs. If the condition still holds when the delay expires, the block turns both FET gates off (logic high), latches them off, and puts the pack into sleep. In sleep the regulator enable is dropped and host register accesses are refused.

A wake input ends sleep and starts a recovery interval. The interval lasts the longer of the two programmed delays plus a fixed guard time. Host accesses are refused until the interval has elapsed. After that, the host releases each FET separately by writing a one-shot release bit. A persistent charge-allow bit decides whether a cell under its charge-enable level forces the charge gate off. Both delays are host-writable registers counted in milliseconds.

Top module: `uvprot_seq`

## Requirements
- R1: Once an under-voltage flag is seen in normal mode, the trip happens on the TUV-th `ms_tick` counted from the following cycle on, provided some flag is still asserted in that cycle. Cycles without a tick do not advance the delay.
- R2: If every under-voltage flag clears before the delay expires, the delay is abandoned and the block stays in normal mode. Both gates stay on (low) during qualification.
- R3: A trip drives `dsg_off` and `chg_off` high in the cycle after the expiring tick, and both stay latched high.
- R4: A trip enters sleep: `sleep` is high and `reg_en` is low. Any host access made while asleep gets no `host_ack`, and a write made while asleep changes no register.
- R5: Sleep is left only when `wake` is high at a clock edge. `sleep` falls and `reg_en` rises after that edge.
- R6: After wake, host accesses are refused until max(TUV, TOV) + GUARD_MS ticks have been counted. The tick at the wake edge counts as none of them. The first access honoured is the one at the edge after the last counted tick.
- R7: Address 0 bit 0 is the discharge release. Writing 1 there clears `dsg_off` two edges after the write edge. Without that write, `dsg_off` stays high.
- R8: Address 0 bit 1 is the charge release. Writing 1 there clears the charge latch two edges after the write edge, and only a charge-release write clears it.
- R9: Address 0 bit 2 is the charge-allow bit (reset value 1). While it is 0 and any charge-enable-low flag is set, `chg_off` is high whatever the release state. While it is 1, those flags have no effect.
- R10: The register map is address 1 = TUV and address 2 = TOV, both readable and writable. Address 0 reads back only the charge-allow bit, at bit 2, because the release bits clear themselves and read as zero. `host_ack` and `host_rdata` appear one edge after the request edge.
- R11: After reset the block is in normal mode with both gates on, `reg_en` high, `sleep` low, TUV = TUV_RST and TOV = TOV_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| uv_flag | input | NCELL | Per-cell under-voltage flags |
| lowce_flag | input | NCELL | Per-cell below-charge-enable flags |
| wake | input | 1 | Wake request that ends sleep |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | DLY_W | Write data |
| host_rdata | output | DLY_W | Read data, registered |
| host_ack | output | 1 | Access accepted, registered |
| dsg_off | output | 1 | Discharge FET gate off (high = off) |
| chg_off | output | 1 | Charge FET gate off (high = off) |
| reg_en | output | 1 | Regulator enable |
| sleep | output | 1 | Sleep indicator |

## Verification
The assertions assume that `host_wr` and `host_rd` are never high in the same cycle. They also assume that a wake request arrives only while the block is asleep, or is harmless otherwise. Every input is taken to be synchronous to `clk`. The bench changes every input just after a falling edge, never raises both strobes at once, and holds `wake` for exactly one cycle while the block sleeps. Each configuration starts from a fresh reset, so the flags never change in the middle of a host transaction.

// File: rtl/uvprot_pkg.sv
package uvprot_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_QUAL  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } uvp_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TUV  = 2'd1;
    localparam logic [1:0] ADDR_TOV  = 2'd2;

    localparam int BIT_REL_DSG = 0;
    localparam int BIT_REL_CHG = 1;
    localparam int BIT_ALLOW   = 2;
endpackage

// File: rtl/uvprot_hostif.sv
module uvprot_hostif
    import uvprot_pkg::*;
#(
    parameter int DLY_W   = 8,
    parameter int TUV_RST = 3,
    parameter int TOV_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access_ok,
    input  logic             wr,
    input  logic             rd,
    input  logic [1:0]       addr,
    input  logic [DLY_W-1:0] wdata,
    output logic             ack,
    output logic [DLY_W-1:0] rdata,
    output logic [DLY_W-1:0] tuv,
    output logic [DLY_W-1:0] tov,
    output logic             allow,
    output logic             clr_dsg,
    output logic             clr_chg
);
    typedef struct packed {
        logic [DLY_W-1:0] tuv;
        logic [DLY_W-1:0] tov;
        logic             allow;
        logic             clr_dsg;
        logic             clr_chg;
        logic             ack;
        logic [DLY_W-1:0] rdata;
    } host_t;

    host_t reg_d, reg_q;

    always_comb begin
        reg_d         = reg_q;
        reg_d.clr_dsg = 1'b0;
        reg_d.clr_chg = 1'b0;
        reg_d.ack     = 1'b0;
        reg_d.rdata   = '0;
        if (access_ok && (wr || rd)) begin
            reg_d.ack = 1'b1;
        end
        if (access_ok && wr) begin
            unique case (addr)
                ADDR_CTRL: begin
                    reg_d.clr_dsg = wdata[BIT_REL_DSG];
                    reg_d.clr_chg = wdata[BIT_REL_CHG];
                    reg_d.allow   = wdata[BIT_ALLOW];
                end
                ADDR_TUV: reg_d.tuv = wdata;
                ADDR_TOV: reg_d.tov = wdata;
                default: ;
            endcase
        end else if (access_ok && rd) begin
            unique case (addr)
                ADDR_CTRL: reg_d.rdata[BIT_ALLOW] = reg_q.allow;
                ADDR_TUV:  reg_d.rdata = reg_q.tuv;
                ADDR_TOV:  reg_d.rdata = reg_q.tov;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.tuv     <= DLY_W'(TUV_RST);
            reg_q.tov     <= DLY_W'(TOV_RST);
            reg_q.allow   <= 1'b1;
            reg_q.clr_dsg <= 1'b0;
            reg_q.clr_chg <= 1'b0;
            reg_q.ack     <= 1'b0;
            reg_q.rdata   <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign ack     = reg_q.ack;
    assign rdata   = reg_q.rdata;
    assign tuv     = reg_q.tuv;
    assign tov     = reg_q.tov;
    assign allow   = reg_q.allow;
    assign clr_dsg = reg_q.clr_dsg;
    assign clr_chg = reg_q.clr_chg;
endmodule

// File: rtl/uvprot_fsm.sv
module uvprot_fsm
    import uvprot_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int GUARD_MS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             uv_any,
    input  logic             wake,
    input  logic [DLY_W-1:0] tuv,
    input  logic [DLY_W-1:0] tov,
    output logic             trip,
    output logic             asleep,
    output logic             access_ok
);
    localparam int CNT_W = $clog2((1 << DLY_W) + GUARD_MS) + 1;

    typedef struct packed {
        uvp_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] tuv_ext;
    logic [DLY_W-1:0] longer;
    logic [CNT_W-1:0] rec_lim;

    always_comb begin
        cnt_inc = seq_q.cnt + CNT_W'(1);
        tuv_ext = CNT_W'(tuv);
        longer  = (tov > tuv) ? tov : tuv;
        rec_lim = CNT_W'(longer) + CNT_W'(GUARD_MS);
        seq_d   = seq_q;
        trip    = 1'b0;
        unique case (seq_q.state)
            ST_RUN: begin
                if (uv_any) begin
                    seq_d.state = ST_QUAL;
                    seq_d.cnt   = '0;
                end
            end
            ST_QUAL: begin
                if (!uv_any) begin
                    seq_d.state = ST_RUN;
                    seq_d.cnt   = '0;
                end else if (ms_tick) begin
                    if (cnt_inc >= tuv_ext) begin
                        trip        = 1'b1;
                        seq_d.state = ST_SLEEP;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = cnt_inc;
                    end
                end
            end
            ST_SLEEP: begin
                if (wake) begin
                    seq_d.state = ST_WAKE;
                    seq_d.cnt   = '0;
                end
            end
            ST_WAKE: begin
                if (ms_tick) begin
                    if (cnt_inc >= rec_lim) begin
                        seq_d.state = ST_RUN;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = cnt_inc;
                    end
                end
            end
            default: seq_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_RUN;
            seq_q.cnt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign asleep    = (seq_q.state == ST_SLEEP);
    assign access_ok = (seq_q.state == ST_RUN) || (seq_q.state == ST_QUAL);
endmodule

// File: rtl/uvprot_fetctl.sv
module uvprot_fetctl (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr_dsg,
    input  logic clr_chg,
    input  logic block_chg,
    output logic dsg_off,
    output logic chg_off
);
    typedef struct packed {
        logic dsg;
        logic chg;
    } fet_t;

    fet_t fet_d, fet_q;

    always_comb begin
        fet_d = fet_q;
        if (trip) begin
            fet_d.dsg = 1'b1;
            fet_d.chg = 1'b1;
        end else begin
            if (clr_dsg) fet_d.dsg = 1'b0;
            if (clr_chg) fet_d.chg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fet_q <= '0;
        end else begin
            fet_q <= fet_d;
        end
    end

    assign dsg_off = fet_q.dsg;
    assign chg_off = fet_q.chg | block_chg;
endmodule

// File: rtl/uvprot_seq.sv
module uvprot_seq
    import uvprot_pkg::*;
#(
    parameter int NCELL    = 4,
    parameter int DLY_W    = 8,
    parameter int TUV_RST  = 3,
    parameter int TOV_RST  = 2,
    parameter int GUARD_MS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [NCELL-1:0] uv_flag,
    input  logic [NCELL-1:0] lowce_flag,
    input  logic             wake,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    input  logic [DLY_W-1:0] host_wdata,
    output logic [DLY_W-1:0] host_rdata,
    output logic             host_ack,
    output logic             dsg_off,
    output logic             chg_off,
    output logic             reg_en,
    output logic             sleep
);
    logic             trip;
    logic             asleep;
    logic             access_ok;
    logic [DLY_W-1:0] tuv;
    logic [DLY_W-1:0] tov;
    logic             allow;
    logic             clr_dsg;
    logic             clr_chg;
    logic             block_chg;

    uvprot_hostif #(
        .DLY_W  (DLY_W),
        .TUV_RST(TUV_RST),
        .TOV_RST(TOV_RST)
    ) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .access_ok(access_ok),
        .wr       (host_wr),
        .rd       (host_rd),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .ack      (host_ack),
        .rdata    (host_rdata),
        .tuv      (tuv),
        .tov      (tov),
        .allow    (allow),
        .clr_dsg  (clr_dsg),
        .clr_chg  (clr_chg)
    );

    uvprot_fsm #(
        .DLY_W   (DLY_W),
        .GUARD_MS(GUARD_MS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .uv_any   (|uv_flag),
        .wake     (wake),
        .tuv      (tuv),
        .tov      (tov),
        .trip     (trip),
        .asleep   (asleep),
        .access_ok(access_ok)
    );

    assign block_chg = !allow && (|lowce_flag);

    uvprot_fetctl u_fet (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip     (trip),
        .clr_dsg  (clr_dsg),
        .clr_chg  (clr_chg),
        .block_chg(block_chg),
        .dsg_off  (dsg_off),
        .chg_off  (chg_off)
    );

    assign sleep  = asleep;
    assign reg_en = !asleep;
endmodule

// File: rtl/uvprot_chk.sv
module uvprot_chk #(
    parameter int NCELL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCELL-1:0] uv_flag,
    input logic             wake,
    input logic             clr_dsg,
    input logic             dsg_off,
    input logic             chg_off,
    input logic             sleep,
    input logic             host_ack
);
    // R3: while asleep both gates are off
    a_r3_sleep_fets_off: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (dsg_off && chg_off));

    // R1: a trip only happens while some cell flag is set
    a_r1_trip_needs_uv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsg_off) |-> $past(|uv_flag));

    // R4: no access is acknowledged for a request made in sleep
    a_r4_no_ack_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !host_ack);

    // R5: sleep ends only through wake
    a_r5_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> $past(wake));

    // R7: the discharge gate turns on only after a release pulse
    a_r7_dsg_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsg_off) |-> $past(clr_dsg));
endmodule

bind uvprot_seq uvprot_chk #(.NCELL(NCELL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .uv_flag (uv_flag),
    .wake    (wake),
    .clr_dsg (clr_dsg),
    .dsg_off (dsg_off),
    .chg_off (chg_off),
    .sleep   (sleep),
    .host_ack(host_ack)
);

// File: tb/uvprot_seq_tb.sv
module uvprot_seq_tb;
    localparam int NCELL = 4;
    localparam int DLY_W = 8;
    localparam int GUARD = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ms_tick = 1'b1;
    logic [NCELL-1:0] uv_flag = '0;
    logic [NCELL-1:0] lowce_flag = '0;
    logic             wake = 1'b0;
    logic             host_wr = 1'b0;
    logic             host_rd = 1'b0;
    logic [1:0]       host_addr = '0;
    logic [DLY_W-1:0] host_wdata = '0;
    logic [DLY_W-1:0] host_rdata;
    logic             host_ack;
    logic             dsg_off, chg_off, reg_en, sleep;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uvprot_seq #(
        .NCELL(NCELL), .DLY_W(DLY_W), .TUV_RST(3), .TOV_RST(2), .GUARD_MS(GUARD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .uv_flag(uv_flag),
        .lowce_flag(lowce_flag), .wake(wake), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .dsg_off(dsg_off), .chg_off(chg_off),
        .reg_en(reg_en), .sleep(sleep)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ms_tick = 1'b1; uv_flag = '0; lowce_flag = '0;
        wake = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DLY_W-1:0] d, output logic ack);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        ack = host_ack;
    endtask

    task automatic rd(input logic [1:0] a, output logic ack, output logic [DLY_W-1:0] d);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        ack = host_ack;
        d = host_rdata;
    endtask

    task automatic trip_it();
        uv_flag = 4'b0010;
        idle(20);
        uv_flag = '0;
        idle(2);
    endtask

    task automatic wake_pulse();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    initial begin
        logic             ack;
        logic [DLY_W-1:0] d;
        do_reset();
        // R11 reset state
        chk("R11 dsg_off", dsg_off, 0);
        chk("R11 chg_off", chg_off, 0);
        chk("R11 reg_en", reg_en, 1);
        chk("R11 sleep", sleep, 0);
        rd(2'd1, ack, d);
        chk("R11 tuv default", d, 3);
        rd(2'd2, ack, d);
        chk("R11 tov default", d, 2);
        chk("R10 read ack", ack, 1);

        // R1 R2 R3 sweep: qualify delay vs pulse length
        for (int t = 1; t <= 4; t++) begin
            for (int k = 1; k <= 6; k++) begin
                do_reset();
                wr(2'd1, DLY_W'(t), ack);
                uv_flag = 4'b0001 << (k % NCELL);
                idle(k);
                uv_flag = '0;
                idle(3);
                if (k >= t + 1) begin
                    chk("R1 R3 trip dsg", dsg_off, 1);
                    chk("R3 trip chg", chg_off, 1);
                    chk("R4 sleep", sleep, 1);
                    chk("R4 reg_en", reg_en, 0);
                end else begin
                    chk("R2 no trip dsg", dsg_off, 0);
                    chk("R2 no trip chg", chg_off, 0);
                    chk("R2 no sleep", sleep, 0);
                end
            end
        end

        // R1 delay without ticks does not advance
        do_reset();
        ms_tick = 1'b0;
        uv_flag = 4'b1000;
        idle(20);
        chk("R1 no tick no trip", dsg_off, 0);
        chk("R1 no tick no sleep", sleep, 0);
        uv_flag = '0;
        ms_tick = 1'b1;

        // R4 R5 R6 R7 R8 R10 sleep, wake, recovery, release
        do_reset();
        trip_it();
        chk("R4 asleep", sleep, 1);
        wr(2'd1, 8'd9, ack);
        chk("R4 write refused ack", ack, 0);
        rd(2'd1, ack, d);
        chk("R4 read refused ack", ack, 0);
        idle(5);
        chk("R5 stays asleep", sleep, 1);
        wake_pulse();
        chk("R5 sleep falls", sleep, 0);
        chk("R5 reg_en rises", reg_en, 1);
        idle(3 + GUARD - 1);
        rd(2'd1, ack, d);
        chk("R6 last refused", ack, 0);
        rd(2'd1, ack, d);
        chk("R6 first honoured", ack, 1);
        chk("R4 sleep write ignored", d, 3);
        chk("R7 still off", dsg_off, 1);
        chk("R8 still off", chg_off, 1);
        wr(2'd2, 8'd12, ack);
        wr(2'd0, 8'h04, ack);
        idle(2);
        chk("R7 no release without bit", dsg_off, 1);
        wr(2'd0, 8'h05, ack);
        idle(1);
        chk("R7 dsg released", dsg_off, 0);
        chk("R8 chg kept", chg_off, 1);
        wr(2'd0, 8'h06, ack);
        idle(1);
        chk("R8 chg released", chg_off, 0);
        rd(2'd0, ack, d);
        chk("R10 ctrl readback", d, 8'h04);

        // R6 with the longer TOV
        trip_it();
        wake_pulse();
        idle(12 + GUARD - 1);
        rd(2'd2, ack, d);
        chk("R6 tov last refused", ack, 0);
        rd(2'd2, ack, d);
        chk("R6 tov honoured", ack, 1);
        chk("R10 tov readback", d, 12);
        wr(2'd0, 8'h07, ack);
        idle(1);
        chk("R7 released again", dsg_off, 0);
        chk("R8 released again", chg_off, 0);

        // R9 charge-allow hold
        wr(2'd0, 8'h00, ack);
        lowce_flag = 4'b0100;
        idle(1);
        chk("R9 held off", chg_off, 1);
        chk("R9 dsg unaffected", dsg_off, 0);
        wr(2'd0, 8'h02, ack);
        idle(2);
        chk("R9 release bit no effect", chg_off, 1);
        lowce_flag = '0;
        idle(1);
        chk("R9 flag clear", chg_off, 0);
        wr(2'd0, 8'h04, ack);
        lowce_flag = 4'b1111;
        idle(1);
        chk("R9 allow ignores flag", chg_off, 0);
        lowce_flag = '0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule